// File: doc/BRIEF.md
# Two-Processor Mailbox Run-Ownership Controller

This controller lets two processors share one system while only one of them executes at any time. The primary processor loads a command code and a small set of argument words into mailbox registers, then writes a dedicated switch register. The controller halts the primary processor and, after a short gap in which neither processor runs, starts the I/O processor. The I/O processor reads the command, does the work, writes a completion status and writes its own switch register. The controller then halts it and, after another gap, restarts the primary processor, which reads the status to decide what to do next.

Each processor reaches the mailbox through its own simple register port: an address, a write strobe, write data and combinational read data. Both ports see the same register layout. Address 0 holds the command, addresses 1 to NUM_ARGS hold the arguments, address NUM_ARGS+1 holds the status and address NUM_ARGS+2 is the switch register. Every other address reads as zero. A text console is a typical client: each output character makes a full round trip through the mailbox, so the dead gap and the switch latency are paid twice per character.

Top module: `mbx_handoff_ctrl`

## Requirements
- R1: After reset the I/O processor runs (`io_run`=1, `pri_run`=0), the command, argument and status registers read 0, and `busy` and `err` are 0.
- R2: A primary-port write to address 0 or to addresses 1..NUM_ARGS stores the data. The stored value reads back on both ports from the next cycle.
- R3: A primary-port write to the switch address while `pri_run`=1 drops `pri_run` after the clock edge. Both run outputs then stay low for exactly DEAD_CYCLES cycles, and `io_run` rises after that.
- R4: `pri_run` and `io_run` are never both 1 in the same cycle.
- R5: From the cycle after an accepted primary switch, the status address reads BUSY_CODE and `busy`=1. This holds until an I/O-port write to the status address. From the next cycle the status then reads the written value and `busy`=0.
- R6: An I/O-port write to the switch address while `io_run`=1 drops `io_run` after the clock edge. Both run outputs then stay low for exactly DEAD_CYCLES cycles, and `pri_run` rises after that.
- R7: A switch write from a port whose processor is not running has no effect on either run output. This includes a switch write during a gap. Such a write sets `err`, and `err` stays 1 until reset.
- R8: I/O-port writes to the command or argument addresses are ignored. Primary-port writes to the status address are ignored. The affected registers keep their values, as read back on the ports.
- R9: Writes to command or argument addresses never start a handoff. A running primary processor keeps `pri_run`=1 after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_addr | input | ADDR_W | Primary port register address |
| pri_we | input | 1 | Primary port write strobe |
| pri_wdata | input | DATA_W | Primary port write data |
| pri_rdata | output | DATA_W | Primary port read data (combinational) |
| io_addr | input | ADDR_W | I/O port register address |
| io_we | input | 1 | I/O port write strobe |
| io_wdata | input | DATA_W | I/O port write data |
| io_rdata | output | DATA_W | I/O port read data (combinational) |
| pri_run | output | 1 | Run enable of the primary processor |
| io_run | output | 1 | Run enable of the I/O processor |
| busy | output | 1 | A request is outstanding and its status is not yet final |
| err | output | 1 | Sticky flag: a switch was requested by a processor that was not running |

## Verification
The bench builds the block with NUM_ARGS=3, ADDR_W=3, DATA_W=8, DEAD_CYCLES=2 and BUSY_CODE=8'hA5. A two-cycle gap exercises the counter variant of the gap timer, not the single-cycle shortcut. It also allows a switch to be attempted inside a gap to test rejection. With three arguments the status and switch sit at addresses 4 and 5, and addresses 6 and 7 are left unused. This shows that reads of unmapped addresses return zero and that the decoder's bounds hold for every argument slot. The busy code is chosen so that it cannot be confused with any status value the bench writes.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   typedef enum logic [1:0] {
      OWN_IO     = 2'd0,
      GAP_TO_PRI = 2'd1,
      OWN_PRI    = 2'd2,
      GAP_TO_IO  = 2'd3
   } owner_e;

   typedef struct packed {
      logic wr_cmd;
      logic wr_arg;
      logic wr_stat;
      logic wr_sw;
   } port_req_t;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
   import mbx_pkg::*;
#(
   parameter int unsigned ADDR_W     = 3,
   parameter int unsigned NUM_ARGS   = 4,
   parameter bit          MAIL_WRITE = 1'b1,
   parameter bit          STAT_WRITE = 1'b0,
   localparam int unsigned IDX_W     = idx_width(NUM_ARGS)
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   output port_req_t         req,
   output logic [IDX_W-1:0]  arg_idx
);

   localparam logic [ADDR_W-1:0] A_CMD  = '0;
   localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(NUM_ARGS);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(NUM_ARGS + 1);
   localparam logic [ADDR_W-1:0] A_SW   = ADDR_W'(NUM_ARGS + 2);

   logic [ADDR_W-1:0] off;

   assign off     = addr - ADDR_W'(1);
   assign arg_idx = IDX_W'(off);

   always_comb begin
      req = '0;
      if (we) begin
         if (addr == A_CMD) begin
            req.wr_cmd = MAIL_WRITE;
         end else if (addr <= A_LAST) begin
            req.wr_arg = MAIL_WRITE;
         end else if (addr == A_STAT) begin
            req.wr_stat = STAT_WRITE;
         end else if (addr == A_SW) begin
            req.wr_sw = 1'b1;
         end
      end
   end

endmodule

// File: rtl/mbx_owner_fsm.sv
module mbx_owner_fsm
   import mbx_pkg::*;
#(
   parameter int unsigned DEAD_CYCLES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pri_sw_req,
   input  logic io_sw_req,
   output logic pri_sw_ok,
   output logic io_sw_ok,
   output logic pri_run,
   output logic io_run,
   output logic err
);

   owner_e state_q, state_d;
   logic   gap_done;
   logic   in_gap;
   logic   bad_req;
   logic   err_q;

   assign pri_sw_ok = pri_sw_req && (state_q == OWN_PRI);
   assign io_sw_ok  = io_sw_req  && (state_q == OWN_IO);
   assign bad_req   = (pri_sw_req && (state_q != OWN_PRI)) ||
                      (io_sw_req  && (state_q != OWN_IO));
   assign in_gap    = (state_q == GAP_TO_PRI) || (state_q == GAP_TO_IO);

   generate
      if (DEAD_CYCLES == 1) begin : g_gap_single
         assign gap_done = 1'b1;
      end else begin : g_gap_count
         localparam int unsigned CNT_W = $clog2(DEAD_CYCLES);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (pri_sw_ok || io_sw_ok) begin
               cnt_q <= CNT_W'(DEAD_CYCLES - 1);
            end else if (in_gap && (cnt_q != '0)) begin
               cnt_q <= cnt_q - CNT_W'(1);
            end
         end
         assign gap_done = (cnt_q == '0);
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         OWN_IO:     if (io_sw_ok)  state_d = GAP_TO_PRI;
         GAP_TO_PRI: if (gap_done)  state_d = OWN_PRI;
         OWN_PRI:    if (pri_sw_ok) state_d = GAP_TO_IO;
         GAP_TO_IO:  if (gap_done)  state_d = OWN_IO;
         default:                   state_d = OWN_IO;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= OWN_IO;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (bad_req) err_q <= 1'b1;
      end
   end

   assign pri_run = (state_q == OWN_PRI);
   assign io_run  = (state_q == OWN_IO);
   assign err     = err_q;

endmodule

// File: rtl/mbx_store.sv
module mbx_store
   import mbx_pkg::*;
#(
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_ARGS  = 4,
   parameter logic [DATA_W-1:0] BUSY_CODE = '1,
   localparam int unsigned IDX_W    = idx_width(NUM_ARGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  port_req_t         pri_req,
   input  logic [IDX_W-1:0]  pri_idx,
   input  logic [DATA_W-1:0] pri_wdata,
   input  port_req_t         io_req,
   input  logic [DATA_W-1:0] io_wdata,
   input  logic              pri_sw_ok,
   input  logic [ADDR_W-1:0] pri_raddr,
   input  logic [ADDR_W-1:0] io_raddr,
   output logic [DATA_W-1:0] pri_rdata,
   output logic [DATA_W-1:0] io_rdata,
   output logic              busy
);

   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(NUM_ARGS + 1);

   logic [DATA_W-1:0] cmd_q;
   logic [DATA_W-1:0] arg_q [NUM_ARGS];
   logic [DATA_W-1:0] stat_q;
   logic              busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (pri_req.wr_cmd) begin
         cmd_q <= pri_wdata;
      end
   end

   generate
      for (genvar i = 0; i < NUM_ARGS; i++) begin : g_arg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               arg_q[i] <= '0;
            end else if (pri_req.wr_arg && (pri_idx == IDX_W'(i))) begin
               arg_q[i] <= pri_wdata;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         busy_q <= 1'b0;
      end else if (pri_sw_ok) begin
         stat_q <= BUSY_CODE;
         busy_q <= 1'b1;
      end else if (io_req.wr_stat) begin
         stat_q <= io_wdata;
         busy_q <= 1'b0;
      end
   end

   assign busy = busy_q;

   logic [ADDR_W-1:0] raddr [2];
   logic [DATA_W-1:0] rdata [2];

   assign raddr[0]  = pri_raddr;
   assign raddr[1]  = io_raddr;
   assign pri_rdata = rdata[0];
   assign io_rdata  = rdata[1];

   generate
      for (genvar p = 0; p < 2; p++) begin : g_rd
         always_comb begin
            rdata[p] = '0;
            if (raddr[p] == '0) begin
               rdata[p] = cmd_q;
            end else if (raddr[p] == A_STAT) begin
               rdata[p] = stat_q;
            end else begin
               for (int k = 0; k < NUM_ARGS; k++) begin
                  if (raddr[p] == ADDR_W'(k + 1)) rdata[p] = arg_q[k];
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/mbx_handoff_ctrl.sv
module mbx_handoff_ctrl
   import mbx_pkg::*;
#(
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned NUM_ARGS    = 4,
   parameter int unsigned DEAD_CYCLES = 1,
   parameter logic [DATA_W-1:0] BUSY_CODE = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] pri_addr,
   input  logic              pri_we,
   input  logic [DATA_W-1:0] pri_wdata,
   output logic [DATA_W-1:0] pri_rdata,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_we,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   output logic              pri_run,
   output logic              io_run,
   output logic              busy,
   output logic              err
);

   localparam int unsigned IDX_W = idx_width(NUM_ARGS);

   generate
      if (NUM_ARGS < 1) begin : g_bad_args
         $error("NUM_ARGS must be at least 1");
      end
      if ((NUM_ARGS + 3) > (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too narrow for the mailbox map");
      end
      if (DEAD_CYCLES < 1) begin : g_bad_gap
         $error("DEAD_CYCLES must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
   endgenerate

   port_req_t        pri_req, io_req;
   logic [IDX_W-1:0] pri_idx, io_idx_unused;
   logic             pri_sw_ok, io_sw_ok;

   mbx_port_dec #(
      .ADDR_W(ADDR_W), .NUM_ARGS(NUM_ARGS),
      .MAIL_WRITE(1'b1), .STAT_WRITE(1'b0)
   ) u_pri_dec (
      .addr(pri_addr), .we(pri_we), .req(pri_req), .arg_idx(pri_idx)
   );

   mbx_port_dec #(
      .ADDR_W(ADDR_W), .NUM_ARGS(NUM_ARGS),
      .MAIL_WRITE(1'b0), .STAT_WRITE(1'b1)
   ) u_io_dec (
      .addr(io_addr), .we(io_we), .req(io_req), .arg_idx(io_idx_unused)
   );

   mbx_owner_fsm #(
      .DEAD_CYCLES(DEAD_CYCLES)
   ) u_owner (
      .clk(clk), .rst_n(rst_n),
      .pri_sw_req(pri_req.wr_sw), .io_sw_req(io_req.wr_sw),
      .pri_sw_ok(pri_sw_ok), .io_sw_ok(io_sw_ok),
      .pri_run(pri_run), .io_run(io_run), .err(err)
   );

   mbx_store #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .NUM_ARGS(NUM_ARGS), .BUSY_CODE(BUSY_CODE)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .pri_req(pri_req), .pri_idx(pri_idx), .pri_wdata(pri_wdata),
      .io_req(io_req), .io_wdata(io_wdata),
      .pri_sw_ok(pri_sw_ok),
      .pri_raddr(pri_addr), .io_raddr(io_addr),
      .pri_rdata(pri_rdata), .io_rdata(io_rdata),
      .busy(busy)
   );

endmodule

// File: rtl/mbx_handoff_chk.sv
module mbx_handoff_chk #(
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned NUM_ARGS    = 4,
   parameter logic [DATA_W-1:0] BUSY_CODE = '1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] pri_addr,
   input logic              pri_we,
   input logic [DATA_W-1:0] pri_rdata,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_we,
   input logic              pri_run,
   input logic              io_run,
   input logic              busy,
   input logic              err
);

   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(NUM_ARGS + 1);
   localparam logic [ADDR_W-1:0] A_SW   = ADDR_W'(NUM_ARGS + 2);

   p_one_runner_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(pri_run && io_run));

   p_gap_before_io_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(io_run) |-> !$past(pri_run));

   p_gap_before_pri_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pri_run) |-> !$past(io_run));

   p_switch_halts_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pri_run && pri_we && pri_addr == A_SW) |=> (!pri_run && !io_run && busy));

   p_io_switch_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (io_run && io_we && io_addr == A_SW) |=> (!pri_run && !io_run));

   p_busy_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && pri_addr == A_STAT) |-> (pri_rdata == BUSY_CODE));

   p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   p_stray_switch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!pri_run && pri_we && pri_addr == A_SW) |=> err);

   p_stray_io_switch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!io_run && io_we && io_addr == A_SW) |=> err);

   p_mail_no_switch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pri_run && pri_we && pri_addr != A_SW) |=> pri_run);

endmodule

bind mbx_handoff_ctrl mbx_handoff_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W),
   .NUM_ARGS(NUM_ARGS), .BUSY_CODE(BUSY_CODE)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .pri_addr(pri_addr), .pri_we(pri_we), .pri_rdata(pri_rdata),
   .io_addr(io_addr), .io_we(io_we),
   .pri_run(pri_run), .io_run(io_run), .busy(busy), .err(err)
);

// File: tb/tb_mbx_handoff_ctrl.sv
module tb_mbx_handoff_ctrl;

   localparam int unsigned ADDR_W = 3;
   localparam int unsigned DATA_W = 8;
   localparam int unsigned NARGS  = 3;
   localparam int unsigned DEAD   = 2;
   localparam logic [7:0]  BUSYV  = 8'hA5;
   localparam logic [2:0]  A_CMD  = 3'd0;
   localparam logic [2:0]  A_STAT = 3'd4;
   localparam logic [2:0]  A_SW   = 3'd5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] pri_addr = '0, io_addr = '0;
   logic       pri_we = 1'b0, io_we = 1'b0;
   logic [7:0] pri_wdata = '0, io_wdata = '0;
   logic [7:0] pri_rdata, io_rdata;
   logic       pri_run, io_run, busy, err;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   mbx_handoff_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_ARGS(NARGS),
      .DEAD_CYCLES(DEAD), .BUSY_CODE(BUSYV)
   ) dut (
      .clk(clk), .rst_n(rst_n),
      .pri_addr(pri_addr), .pri_we(pri_we), .pri_wdata(pri_wdata), .pri_rdata(pri_rdata),
      .io_addr(io_addr), .io_we(io_we), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .pri_run(pri_run), .io_run(io_run), .busy(busy), .err(err)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // write through one port: drive at negedge, return at the next negedge
   task automatic wr(input bit io_side, input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      if (io_side) begin io_addr = a; io_wdata = d; io_we = 1'b1; end
      else         begin pri_addr = a; pri_wdata = d; pri_we = 1'b1; end
      @(negedge clk);
      pri_we = 1'b0; io_we = 1'b0;
   endtask

   task automatic rd_chk(input bit io_side, input logic [2:0] a, input logic [7:0] exp, input string req);
      if (io_side) io_addr = a; else pri_addr = a;
      #1;
      check(req, io_side ? io_rdata : pri_rdata, exp);
   endtask

   task automatic run_chk(input logic p, input logic i, input string req);
      check({req, " pri_run"}, pri_run, p);
      check({req, " io_run"}, io_run, i);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      run_chk(1'b0, 1'b1, "R1 reset");
      check("R1 busy", busy, 0);
      check("R1 err", err, 0);
      for (int a = 0; a <= 4; a++) rd_chk(1'b0, 3'(a), 8'h00, "R1 cleared");
   endtask

   task automatic t_io_switch;
      wr(1'b1, A_SW, 8'h00);
      run_chk(1'b0, 1'b0, "R6 gap 1");
      @(negedge clk);
      run_chk(1'b0, 1'b0, "R6 gap 2");
      @(negedge clk);
      run_chk(1'b1, 1'b0, "R6 primary resumes");
   endtask

   task automatic t_fill(input logic [7:0] cmd, input logic [7:0] base);
      wr(1'b0, A_CMD, cmd);
      check("R9 cmd write keeps primary", pri_run, 1);
      for (int k = 1; k <= 3; k++) wr(1'b0, 3'(k), base + 8'(k));
      check("R9 arg writes keep primary", pri_run, 1);
      rd_chk(1'b0, A_CMD, cmd, "R2 cmd pri");
      rd_chk(1'b1, A_CMD, cmd, "R2 cmd io");
      for (int k = 1; k <= 3; k++) rd_chk(1'b1, 3'(k), base + 8'(k), "R2 arg io");
   endtask

   task automatic t_illegal;
      rd_chk(1'b0, A_STAT, 8'h00, "R8 status before");
      wr(1'b0, A_STAT, 8'h3C);
      rd_chk(1'b0, A_STAT, 8'h00, "R8 primary status write ignored");
      rd_chk(1'b0, 3'd6, 8'h00, "R2 unmapped reads zero");
      rd_chk(1'b0, 3'd7, 8'h00, "R2 unmapped reads zero");
   endtask

   task automatic t_stray_io;
      wr(1'b1, A_SW, 8'h00);
      run_chk(1'b1, 1'b0, "R7 stray io switch");
      check("R7 err set", err, 1);
   endtask

   task automatic t_round_trip(input logic [7:0] cmd, input logic [7:0] stat, input bit poke_gap);
      wr(1'b0, A_SW, 8'h00);
      run_chk(1'b0, 1'b0, "R3 gap 1");
      check("R5 busy raised", busy, 1);
      rd_chk(1'b0, A_STAT, BUSYV, "R5 busy code");
      if (poke_gap) begin
         // switch attempt inside the gap
         wr(1'b0, A_SW, 8'h00);
         run_chk(1'b0, 1'b1, "R7 gap switch ignored");
         check("R7 err stays", err, 1);
      end else begin
         @(negedge clk);
         run_chk(1'b0, 1'b0, "R3 gap 2");
         @(negedge clk);
         run_chk(1'b0, 1'b1, "R3 io starts");
      end
      rd_chk(1'b1, A_CMD, cmd, "R2 io sees command");
      wr(1'b1, A_CMD, 8'hEE);
      rd_chk(1'b1, A_CMD, cmd, "R8 io cmd write ignored");
      wr(1'b1, 3'd2, 8'hEE);
      check("R8 io arg write ignored", io_rdata == 8'hEE, 0);
      rd_chk(1'b1, A_STAT, BUSYV, "R5 still busy");
      wr(1'b1, A_STAT, stat);
      check("R5 busy cleared", busy, 0);
      rd_chk(1'b1, A_STAT, stat, "R5 final status");
      t_io_switch();
      rd_chk(1'b0, A_STAT, stat, "R5 primary reads status");
   endtask

   initial begin
      t_reset();
      t_io_switch();
      t_fill(8'h11, 8'h20);
      t_illegal();
      t_stray_io();
      t_round_trip(8'h11, 8'h01, 1'b0);
      t_fill(8'h48, 8'h40);
      t_round_trip(8'h48, 8'h00, 1'b1);
      t_fill(8'h69, 8'h70);
      t_round_trip(8'h69, 8'h7F, 1'b0);
      check("R7 err sticky at end", err, 1);
      t_reset();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule